// File: doc/BRIEF.md
# Run-Time Modulus Johnson Divider

This block is a five-stage twisted-ring counter that divides its clock by any whole number from 2 to 10. The value on the modulus select input sets how many stages form the ring and which stage feeds the inverted bit back into the first stage. For an odd modulus the feedback also looks at the stage just below the tap, which drops one state from the cycle. The tap stage is the divided-clock output. For an even modulus it is a square wave. For an odd modulus its high time is one cycle shorter than its low time.

A synchronous clear and a parallel load let the controlling logic put the ring into a known state. The load can be any pattern. The counter therefore corrects itself. A word that no legal ring can hold goes to all-zero on the next count step. Stages above the active ring are cleared on every count step. A one-cycle marker output flags each return to the all-zero state, so the period can be measured from outside.

Top module: `johnson_divider`

## Requirements
- R1: The five stages are visible on `stage_q` (bit 0 is the first stage). On a count step the first stage takes the feedback bit, and each active stage i (index below k) takes stage i-1.
- R2: For an even effective modulus M = 2k, the feedback bit is the inverse of stage k (bit k-1). Starting from all-zero, the state returns to all-zero every M count steps.
- R3: When `clr` is high at a rising clock edge, every stage becomes 0. This holds even if `load_en` is also high.
- R4: When `load_en` is high and `clr` is low at a rising edge, `stage_q` takes `load_val` (bit 0 goes to the first stage).
- R5: For an odd effective modulus M = 2k-1, the feedback bit is the inverse of (bit k-1 OR bit k-2). Starting from all-zero, the period is M count steps.
- R6: `mod_sel` values 2 to 10 select that modulus. The values 0, 1 and 11 to 15 select 10.
- R7: `wrap_pulse` is high for exactly one cycle, in the cycle after a count step that moved a nonzero state to all-zero. It is low at all other times.
- R8: After every count step, the stages at index k and above are 0.
- R9: On a count step, if the active bits 0..k-1 hold more than one change of value between neighbouring bits, the next state is all-zero.
- R10: `div_out` always equals stage bit k-1 of the current state, where k comes from the current `mod_sel`.
- R11: Driving `rst_n` low clears all stages and `wrap_pulse` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear, highest priority |
| load_en | input | 1 | Synchronous parallel load enable |
| load_val | input | 5 | Pattern to load, bit 0 to the first stage |
| mod_sel | input | 4 | Modulus select |
| stage_q | output | 5 | Stage values |
| div_out | output | 1 | Divided clock, taken from the tap stage |
| wrap_pulse | output | 1 | One-cycle marker for each return to all-zero |

## Verification
The hardest states to reach are the illegal ones. Counting from a clear never leaves the legal sequence, so the lock-recovery path can only be entered through the load port. The stimulus loads split-run patterns such as 01010 and 00101, loads ones into stages above a short ring, and during random runs changes the modulus mid-count so that a state legal for a long ring becomes illegal for a short one. Periods are measured from the gap between marker pulses, for every modulus value and for the out-of-range selects.

// File: rtl/jd_pkg.sv
package jd_pkg;
  typedef enum logic [1:0] {
    OP_COUNT = 2'd0,
    OP_LOAD  = 2'd1,
    OP_CLEAR = 2'd2
  } jd_op_e;
endpackage

// File: rtl/jd_mod_decode.sv
module jd_mod_decode #(
  parameter int STAGES = 5,
  parameter int SEL_W  = 4,
  parameter int KW     = 3
) (
  input  logic [SEL_W-1:0]  sel,
  output logic [KW-1:0]     ring_len,
  output logic              odd_mod,
  output logic [STAGES-1:0] ring_mask
);
  localparam int MAX_MOD = 2 * STAGES;

  int eff_mod;

  always_comb begin
    if (int'(sel) >= 2 && int'(sel) <= MAX_MOD) eff_mod = int'(sel);
    else                                          eff_mod = MAX_MOD;
    ring_len = KW'((eff_mod + 1) / 2);
    odd_mod  = (eff_mod % 2) == 1;
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_mask
    assign ring_mask[g] = int'(ring_len) > g;
  end
endmodule

// File: rtl/jd_feedback.sv
module jd_feedback #(
  parameter int STAGES = 5,
  parameter int KW     = 3
) (
  input  logic [STAGES-1:0] q,
  input  logic [KW-1:0]     ring_len,
  input  logic              odd_mod,
  output logic              shift_in,
  output logic              tap
);
  logic hi_bit, lo_bit;

  always_comb begin
    hi_bit = 1'b0;
    lo_bit = 1'b0;
    for (int i = 0; i < STAGES; i++) begin
      if (i == int'(ring_len) - 1)            hi_bit = q[i];
      if (odd_mod && i == int'(ring_len) - 2) lo_bit = q[i];
    end
    shift_in = ~(hi_bit | lo_bit);
    tap      = hi_bit;
  end
endmodule

// File: rtl/jd_lock_guard.sv
module jd_lock_guard #(
  parameter int STAGES = 5
) (
  input  logic [STAGES-1:0] q,
  input  logic [STAGES-1:0] ring_mask,
  output logic              legal
);
  int edges;

  always_comb begin
    edges = 0;
    for (int i = 1; i < STAGES; i++) begin
      if (ring_mask[i] && (q[i] != q[i-1])) edges = edges + 1;
    end
    legal = edges <= 1;
  end
endmodule

// File: rtl/johnson_divider.sv
module johnson_divider #(
  parameter int STAGES = 5,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load_en,
  input  logic [STAGES-1:0] load_val,
  input  logic [SEL_W-1:0]  mod_sel,
  output logic [STAGES-1:0] stage_q,
  output logic              div_out,
  output logic              wrap_pulse
);
  import jd_pkg::*;

  localparam int KW = $clog2(STAGES + 1);

  logic [STAGES-1:0] q_r, q_nxt, shifted, ring_mask;
  logic [KW-1:0]     ring_len;
  logic              odd_mod, shift_in, tap, legal;
  logic              wrap_r, wrap_nxt;
  jd_op_e            op;

  jd_mod_decode #(.STAGES(STAGES), .SEL_W(SEL_W), .KW(KW)) u_decode (
    .sel       (mod_sel),
    .ring_len  (ring_len),
    .odd_mod   (odd_mod),
    .ring_mask (ring_mask)
  );

  jd_feedback #(.STAGES(STAGES), .KW(KW)) u_feedback (
    .q        (q_r),
    .ring_len (ring_len),
    .odd_mod  (odd_mod),
    .shift_in (shift_in),
    .tap      (tap)
  );

  jd_lock_guard #(.STAGES(STAGES)) u_guard (
    .q         (q_r),
    .ring_mask (ring_mask),
    .legal     (legal)
  );

  always_comb begin
    if (clr)          op = OP_CLEAR;
    else if (load_en) op = OP_LOAD;
    else              op = OP_COUNT;

    shifted = {q_r[STAGES-2:0], shift_in} & ring_mask;
    if (!legal) shifted = '0;

    case (op)
      OP_CLEAR: q_nxt = '0;
      OP_LOAD:  q_nxt = load_val;
      default:  q_nxt = shifted;
    endcase

    wrap_nxt = (op == OP_COUNT) && (q_r != '0) && (q_nxt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r    <= '0;
      wrap_r <= 1'b0;
    end else begin
      q_r    <= q_nxt;
      wrap_r <= wrap_nxt;
    end
  end

  assign stage_q    = q_r;
  assign div_out    = tap;
  assign wrap_pulse = wrap_r;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (stage_q == '0)); // R3
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !clr) |=> (stage_q == $past(load_val))); // R4
  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_COUNT) |=> ((stage_q & ~$past(ring_mask)) == '0)); // R8
  AST_LOCK_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_COUNT && !legal) |=> (stage_q == '0)); // R9
  AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |-> (stage_q == '0)); // R7
  AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |=> !wrap_pulse); // R7
endmodule

// File: tb/johnson_divider_bench.sv
module johnson_divider_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       load_en = 1'b0;
  logic [4:0] load_val = '0;
  logic [3:0] mod_sel = 4'd10;
  logic [4:0] stage_q;
  logic       div_out;
  logic       wrap_pulse;

  int checks = 0;
  int errors = 0;
  int mdl = 0;
  bit exp_wrap = 0;
  int cyc = 0;
  int last_wrap = -1;
  string cur = "R1";

  always #10 clk = ~clk;

  johnson_divider u_johnson_divider (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load_en(load_en),
    .load_val(load_val), .mod_sel(mod_sel), .stage_q(stage_q),
    .div_out(div_out), .wrap_pulse(wrap_pulse)
  );

  function automatic int eff_mod(int s);
    return (s >= 2 && s <= 10) ? s : 10;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare_all(int k);
    int edv;
    edv = (mdl >> (k - 1)) & 1;
    chk(stage_q == mdl[4:0], cur, int'(stage_q), mdl);
    chk(div_out == edv[0], "R10", int'(div_out), edv);
    chk(wrap_pulse == exp_wrap, "R7", int'(wrap_pulse), int'(exp_wrap));
  endtask

  task automatic step(bit c, bit l, logic [4:0] v, logic [3:0] s);
    int m, k, mask, prev, nxt, low, hi, lo;
    bit ok;
    clr = c; load_en = l; load_val = v; mod_sel = s;
    @(posedge clk);
    m = eff_mod(int'(s));
    k = (m + 1) / 2;
    mask = (1 << k) - 1;
    prev = mdl;
    if (c) nxt = 0;
    else if (l) nxt = int'(v);
    else begin
      low = mdl & mask;
      ok = 0;
      for (int j = 0; j <= k; j++)
        if (low == ((1 << j) - 1) || low == (mask ^ ((1 << j) - 1))) ok = 1;
      if (!ok) nxt = 0;
      else begin
        hi = (mdl >> (k - 1)) & 1;
        lo = (m % 2 == 1) ? ((mdl >> (k - 2)) & 1) : 0;
        nxt = ((mdl << 1) | (((hi | lo) != 0) ? 0 : 1)) & mask;
      end
    end
    exp_wrap = !c && !l && prev != 0 && nxt == 0;
    mdl = nxt;
    cyc++;
    @(negedge clk);
    compare_all(k);
    if (c) last_wrap = cyc;
    else if (l) last_wrap = -1;
    if (exp_wrap) begin
      if (last_wrap >= 0)
        chk((cyc - last_wrap) == m, (m % 2 == 1) ? "R5" : "R2", cyc - last_wrap, m);
      last_wrap = cyc;
    end
  endtask

  task automatic run_mod(logic [3:0] s, int n, string tag);
    cur = tag;
    step(1, 0, '0, s);
    for (int i = 0; i < n; i++) step(0, 0, '0, s);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    cur = "R11";
    compare_all(5);
    rst_n = 1'b1;

    run_mod(4'd10, 30, "R1");
    for (int s = 2; s <= 10; s++)
      run_mod(4'(s), 3 * s + 2, (s % 2 == 1) ? "R5" : "R2");
    run_mod(4'd0, 25, "R6");
    run_mod(4'd1, 25, "R6");
    run_mod(4'd11, 25, "R6");
    run_mod(4'd15, 25, "R6");

    cur = "R4";
    step(0, 1, 5'b00011, 4'd8);
    for (int i = 0; i < 10; i++) step(0, 0, '0, 4'd8);
    step(0, 1, 5'b11111, 4'd10);
    for (int i = 0; i < 12; i++) step(0, 0, '0, 4'd10);
    step(0, 1, 5'b00110, 4'd6);
    for (int i = 0; i < 8; i++) step(0, 0, '0, 4'd6);
    step(0, 1, 5'b00111, 4'd5);
    for (int i = 0; i < 8; i++) step(0, 0, '0, 4'd5);

    cur = "R3";
    step(0, 1, 5'b10110, 4'd10);
    step(1, 1, 5'b10101, 4'd10);
    step(0, 0, '0, 4'd10);

    cur = "R9";
    step(0, 1, 5'b01010, 4'd10);
    step(0, 0, '0, 4'd10);
    step(0, 0, '0, 4'd10);
    step(0, 1, 5'b00101, 4'd7);
    step(0, 0, '0, 4'd7);
    for (int i = 0; i < 8; i++) step(0, 0, '0, 4'd7);

    cur = "R8";
    step(0, 1, 5'b11100, 4'd4);
    for (int i = 0; i < 6; i++) step(0, 0, '0, 4'd4);
    step(0, 1, 5'b10001, 4'd2);
    for (int i = 0; i < 4; i++) step(0, 0, '0, 4'd2);

    cur = "R1";
    for (int i = 0; i < 600; i++) begin
      int r;
      logic [3:0] s;
      r = int'($urandom_range(0, 99));
      s = 4'($urandom_range(0, 15));
      if (r < 3)       step(1, 0, '0, s);
      else if (r < 10) step(0, 1, 5'($urandom_range(0, 31)), s);
      else if (r < 15) begin last_wrap = -1; step(0, 0, '0, s); last_wrap = -1; end
      else             step(0, 0, '0, mod_sel);
    end

    cur = "R11";
    step(0, 1, 5'b00111, 4'd10);
    step(0, 0, '0, 4'd10);
    rst_n = 1'b0;
    #1;
    mdl = 0;
    exp_wrap = 0;
    compare_all(5);
    @(negedge clk);
    rst_n = 1'b1;
    last_wrap = -1;
    step(0, 0, '0, 4'd10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule